// File: doc/BRIEF.md
# USB Receive Byte Status Window

This block sits between a USB receive datapath and a small embedded processor. The datapath sends it three kinds of strobe: a byte strobe carrying an 8-bit value, a packet-start strobe and a packet-end strobe. From these the block keeps the most recent byte in a holding register and tracks two flags. One flag says a byte is waiting to be collected. The other says a packet is in progress.

Software reaches the block through a narrow read port with a 6-bit address and 8-bit registered read data. The two flags are packed into one status byte. A single read therefore returns both flags as they stood in the same cycle. This closes the polling race in which software sees the last byte arrive, then the packet end, but in two separate reads that straddle the end of the packet. Reading the data register returns the held byte and acknowledges it, which clears the byte-waiting flag.

Top module: `usbrx_status_window`

## Requirements
- R1: After reset, the byte-waiting flag, the packet-active flag, the holding register and the read data output are all zero.
- R2: A byte strobe sets the byte-waiting flag at the next clock edge and loads the byte into the holding register at that edge.
- R3: A read at address 0x09 returns the holding register on the read data output one cycle after the read strobe, and clears the byte-waiting flag at that same edge.
- R4: When a byte strobe and a read at 0x09 fall in the same cycle, the flag stays set, the read returns the byte held before that edge, and the new byte is held afterwards.
- R5: A packet-start strobe sets the packet-active flag and a packet-end strobe clears it. The flag stays set across the whole packet. If both strobes fall in the same cycle, the start wins.
- R6: The holding register changes only on a byte strobe. Reads and packet strobes leave it unchanged.
- R7: A read at address 0x0a returns a status byte with the packet-active flag in bit 0 and the byte-waiting flag in bit 1. Both are taken from the same cycle, the one in which the read strobe is high, and bits 7 to 2 are zero.
- R8: A status read does not clear either flag. A read at any address other than 0x09 or 0x0a (0x0b included) returns zero and has no side effect.
- R9: While the read strobe is low, the read data output keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_stb | input | 1 | A complete byte is delivered this cycle |
| rx_byte | input | 8 | Byte value qualified by rx_byte_stb |
| rx_pkt_start | input | 1 | Packet-start strobe |
| rx_pkt_end | input | 1 | Packet-end strobe |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 6 | Read address |
| io_rdata | output | 8 | Registered read data |

## Verification
The bench first goes after the collision between an arriving byte and a data read. A design in which the clear wins would lose that byte, so the next status read would show no byte waiting. It also places a status read on the very edge where the packet ends. A design that sampled the flags late, or sampled them at different times, would report the packet as already finished. Further checks cover status reads that wrongly clear the flag, holding-register updates without a byte strobe, nonzero upper status bits or unused-address data, and read data that changes while no read is under way.

// File: rtl/usbrx_status_pkg.sv
package usbrx_status_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_BYTE = 6'h09;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 6'h0a;
  localparam int STAT_ACT_BIT  = 0;
  localparam int STAT_PEND_BIT = 1;

  typedef struct packed {
    logic active;
    logic pending;
  } rx_flags_t;

  function automatic logic [DATA_W-1:0] pack_status(input rx_flags_t f);
    logic [DATA_W-1:0] s;
    s = '0;
    s[STAT_ACT_BIT]  = f.active;
    s[STAT_PEND_BIT] = f.pending;
    return s;
  endfunction
endpackage

// File: rtl/usbrx_flag_track.sv
module usbrx_flag_track
  import usbrx_status_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_stb,
  input  logic [DW-1:0] byte_in,
  input  logic          pkt_start,
  input  logic          pkt_end,
  input  logic          ack_byte,
  output rx_flags_t     flags,
  output logic [DW-1:0] hold_q
);
  rx_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      hold_q  <= '0;
    end else begin
      if (byte_stb) begin
        flags_q.pending <= 1'b1;
        hold_q          <= byte_in;
      end else if (ack_byte) begin
        flags_q.pending <= 1'b0;
      end
      if (pkt_start)    flags_q.active <= 1'b1;
      else if (pkt_end) flags_q.active <= 1'b0;
    end
  end

  assign flags = flags_q;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> flags_q.pending); // R2
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_byte && !byte_stb) |=> !flags_q.pending); // R3
  AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> flags_q.active); // R5
  AST_ACT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !pkt_start) |=> !flags_q.active); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_stb |=> $stable(hold_q)); // R6
endmodule

// File: rtl/usbrx_io_read.sv
module usbrx_io_read
  import usbrx_status_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  rx_flags_t     flags,
  input  logic [DW-1:0] hold_q,
  output logic          ack_byte,
  output logic [DW-1:0] rdata
);
  logic          hit_byte;
  logic          hit_stat;
  logic [DW-1:0] rd_mux;

  assign hit_byte = rd && (addr == ADDR_BYTE);
  assign hit_stat = rd && (addr == ADDR_STAT);
  assign ack_byte = hit_byte;

  always_comb begin
    if (hit_byte)      rd_mux = hold_q;
    else if (hit_stat) rd_mux = pack_status(flags);
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stat |=> (rdata[DW-1:2] == '0)); // R7
  AST_STAT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stat |=> (rdata[STAT_ACT_BIT] == $past(flags.active))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R9
  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit_byte && !hit_stat) |=> (rdata == '0)); // R8
endmodule

// File: rtl/usbrx_status_window.sv
module usbrx_status_window
  import usbrx_status_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_byte_stb,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_pkt_start,
  input  logic          rx_pkt_end,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  output logic [DW-1:0] io_rdata
);
  rx_flags_t     flags;
  logic [DW-1:0] hold_q;
  logic          ack_byte;

  usbrx_flag_track #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .byte_stb(rx_byte_stb), .byte_in(rx_byte),
    .pkt_start(rx_pkt_start), .pkt_end(rx_pkt_end),
    .ack_byte(ack_byte), .flags(flags), .hold_q(hold_q)
  );

  usbrx_io_read #(.AW(AW), .DW(DW)) u_read (
    .clk(clk), .rst_n(rst_n),
    .rd(io_rd), .addr(io_addr),
    .flags(flags), .hold_q(hold_q),
    .ack_byte(ack_byte), .rdata(io_rdata)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (io_rdata == '0)); // R1
endmodule

// File: tb/usbrx_status_window_bench.sv
module usbrx_status_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_byte_stb = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_pkt_start = 1'b0;
  logic       rx_pkt_end = 1'b0;
  logic       io_rd = 1'b0;
  logic [5:0] io_addr = '0;
  logic [7:0] io_rdata;
  int tests = 0;
  int fails = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  usbrx_status_window u_usbrx_status_window (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive at negedge, hold across one posedge, sample at the following negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    rx_byte_stb = 0; rx_pkt_start = 0; rx_pkt_end = 0; io_rd = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    io_rd = 1; io_addr = a;
    step();
    d = io_rdata;
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", io_rdata, 8'h00);
    rd(6'h0a, got); check("R1 status after reset", got, 8'h00);
    rd(6'h09, got); check("R1 byte after reset", got, 8'h00);
  endtask

  task automatic t_byte_and_clear();
    rx_byte_stb = 1; rx_byte = 8'hd2; step();
    rd(6'h0a, got); check("R2 pending set", got, 8'h02);
    rd(6'h0a, got); check("R8 status read keeps pending", got, 8'h02);
    rd(6'h09, got); check("R3 byte read", got, 8'hd2);
    rd(6'h0a, got); check("R3 pending cleared", got, 8'h00);
  endtask

  task automatic t_collision();
    rx_byte_stb = 1; rx_byte = 8'h2d; step();
    io_rd = 1; io_addr = 6'h09; rx_byte_stb = 1; rx_byte = 8'h5a; step();
    check("R4 old byte returned", io_rdata, 8'h2d);
    rd(6'h0a, got); check("R4 set wins", got, 8'h02);
    rd(6'h09, got); check("R4 new byte held", got, 8'h5a);
  endtask

  task automatic t_packet();
    rx_pkt_start = 1; step();
    rd(6'h0a, got); check("R5 active set", got, 8'h01);
    rx_byte_stb = 1; rx_byte = 8'h77; step();
    rd(6'h0a, got); check("R7 both flags packed", got, 8'h03);
    // status read on the same edge as packet end: sees pre-edge flags
    io_rd = 1; io_addr = 6'h0a; rx_pkt_end = 1; step();
    check("R7 same-cycle sample", io_rdata, 8'h03);
    rd(6'h0a, got); check("R5 active cleared", got, 8'h02);
    rx_pkt_start = 1; rx_pkt_end = 1; step();
    rd(6'h0a, got); check("R5 start wins", got, 8'h03);
    rx_pkt_end = 1; step();
  endtask

  task automatic t_hold_and_other();
    rx_pkt_start = 1; step();
    rx_pkt_end = 1; step();
    rd(6'h0b, got); check("R8 addr 0x0b zero", got, 8'h00);
    rd(6'h3f, got); check("R8 other addr zero", got, 8'h00);
    rd(6'h0a, got); check("R8 other reads no side effect", got, 8'h02);
    rd(6'h09, got); check("R6 hold unchanged", got, 8'h77);
    rd(6'h09, got); check("R6 hold after ack", got, 8'h77);
    rx_byte = 8'hff; step();
    rd(6'h09, got); check("R6 no strobe no load", got, 8'h77);
  endtask

  task automatic t_idle_hold();
    rx_byte_stb = 1; rx_byte = 8'h3c; step();
    rd(6'h09, got);
    rx_byte_stb = 1; rx_byte = 8'h99; step();
    step(); step();
    check("R9 rdata held while idle", io_rdata, 8'h3c);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_byte_and_clear();
        t_collision();
        t_packet();
        t_hold_and_other();
        t_idle_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule